// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block selects the control-memory address used in the next clock cycle of a microprogrammed control unit. It holds a control address register (CAR), which drives the control memory directly, and a one-level subroutine return register (SBR). Each cycle it reads three fields of the current microinstruction: a 2-bit condition selector, a 2-bit branch kind and a branch target address. It also reads three datapath status flags and the opcode of the fetched machine instruction.

The condition selector picks one of four tests. The branch kind then decides where CAR goes next. It can step in line to CAR+1. It can go to the branch target, either as a jump or as a call that saves the return point. It can return through SBR. It can also dispatch to the first microinstruction of the routine for the current opcode. Reset places CAR at the start of the fetch routine.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low, `car_q` is 64 (the fetch routine start), and the return register is cleared, so a return issued as the first microinstruction after reset goes to address 0.
- R2: `cd_sel` picks the condition as follows: 0 is always true, 1 is `ind_bit`, 2 is `acc_sign`, and 3 is `acc_zero`.
- R3: With `br_kind`=0 (jump), the next `car_q` is `br_addr` when the condition is true and `car_q`+1 when it is false.
- R4: With `br_kind`=1 (call), when the condition is true the next `car_q` is `br_addr` and the return register takes the old `car_q`+1. When the condition is false the next `car_q` is `car_q`+1.
- R5: With `br_kind`=2 (return), the next `car_q` is the return register value, whatever the condition.
- R6: With `br_kind`=3 (dispatch), the next `car_q` places `opcode` in bits [5:2] and clears bits 6, 1 and 0. The condition and `br_addr` have no effect.
- R7: The in-line increment wraps from 127 to 0.
- R8: The return register changes only on a call whose condition is true. Jumps, returns, dispatches and untaken calls leave it unchanged, as seen by a later return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field: 0 jump, 1 call, 2 return, 3 dispatch |
| br_addr | input | 7 | Branch target address field |
| ind_bit | input | 1 | Indirect-address flag of the instruction word |
| acc_sign | input | 1 | Accumulator sign flag |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| opcode | input | 4 | Opcode of the fetched machine instruction |
| car_q | output | 7 | Control address register, the control-memory address |

## Verification
The bench sweeps every combination of branch kind, condition selector, the eight flag patterns and the sixteen opcodes. The branch target changes with each step. This separates a wrongly chosen flag from a wrongly chosen source, and it shows that dispatch ignores both the condition and the target. Directed runs hold a jump at address 127 to show the wrap. They also return right after reset, and they return after a mix of untaken calls and other branches. These three runs show whether the return register was cleared by reset, and whether any branch other than a taken call has disturbed it.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Branch kind field of the microinstruction
  typedef enum logic [1:0] {
    BR_JUMP     = 2'b00,
    BR_CALL     = 2'b01,
    BR_RETURN   = 2'b10,
    BR_DISPATCH = 2'b11
  } br_kind_e;

  // Condition selector field
  typedef enum logic [1:0] {
    CD_ALWAYS   = 2'b00,
    CD_INDIRECT = 2'b01,
    CD_NEG      = 2'b10,
    CD_ZERO     = 2'b11
  } cond_kind_e;

  // Address source select, {s1,s0}
  typedef enum logic [1:0] {
    SRC_INC  = 2'b00,
    SRC_RET  = 2'b01,
    SRC_TGT  = 2'b10,
    SRC_MAP  = 2'b11
  } addr_src_e;

endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
(
  input  logic [1:0] cd_sel,
  input  logic       ind_bit,
  input  logic       acc_sign,
  input  logic       acc_zero,
  output logic       taken
);

  logic [3:0] flag_vec;

  // Index 0 is the constant-true test
  assign flag_vec = {acc_zero, acc_sign, ind_bit, 1'b1};

  always_comb begin
    taken = flag_vec[cd_sel];
  end

endmodule

// File: rtl/useq_src_dec.sv
module useq_src_dec
  import useq_pkg::*;
(
  input  logic [1:0] br_kind,
  input  logic       taken,
  output addr_src_e  src_sel,
  output logic       ret_load
);

  logic kind_hi;
  logic kind_lo;
  logic s1;
  logic s0;

  assign kind_hi = br_kind[1];
  assign kind_lo = br_kind[0];

  // Two-level select logic, one product term per source
  always_comb begin
    s0       = kind_hi;
    s1       = (kind_hi & kind_lo) | (~kind_hi & taken);
    ret_load = ~kind_hi & kind_lo & taken;
    src_sel  = addr_src_e'({s1, s0});
  end

endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int OPC_W   = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [ADDR_W-1:0] car_q,
  input  logic [ADDR_W-1:0] ret_q,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [OPC_W-1:0]  opcode,
  input  addr_src_e         src_sel,
  output logic [ADDR_W-1:0] car_inc,
  output logic [ADDR_W-1:0] car_nxt
);

  localparam int MAP_TOP = MAP_LSB + OPC_W;

  logic [ADDR_W-1:0] map_addr;

  // Incrementer: natural modulo-2^ADDR_W wrap
  assign car_inc = car_q + {{(ADDR_W-1){1'b0}}, 1'b1};

  // Opcode dispatch address: opcode field placed at MAP_LSB, rest zero
  generate
    if (MAP_TOP <= ADDR_W) begin : g_map_fit
      always_comb begin
        map_addr = '0;
        map_addr[MAP_LSB +: OPC_W] = opcode;
      end
    end else begin : g_map_trunc
      always_comb begin
        map_addr = '0;
        for (int i = MAP_LSB; i < ADDR_W; i++) begin
          map_addr[i] = opcode[i-MAP_LSB];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (src_sel)
      SRC_INC: car_nxt = car_inc;
      SRC_RET: car_nxt = ret_q;
      SRC_TGT: car_nxt = br_addr;
      SRC_MAP: car_nxt = map_addr;
      default: car_nxt = car_inc;
    endcase
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int MAP_LSB    = 2,
  parameter int FETCH_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cd_sel,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              ind_bit,
  input  logic              acc_sign,
  input  logic              acc_zero,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] car_q
);

  localparam logic [ADDR_W-1:0] CAR_RST = ADDR_W'(FETCH_ADDR);

  logic              taken;
  addr_src_e         src_sel;
  logic              ret_load;
  logic [ADDR_W-1:0] car_inc;
  logic [ADDR_W-1:0] car_nxt;
  logic [ADDR_W-1:0] sbr_q;
  logic [ADDR_W-1:0] sbr_nxt;
  logic              car_en;

  useq_cond_sel u_cond (
    .cd_sel   (cd_sel),
    .ind_bit  (ind_bit),
    .acc_sign (acc_sign),
    .acc_zero (acc_zero),
    .taken    (taken)
  );

  useq_src_dec u_dec (
    .br_kind  (br_kind),
    .taken    (taken),
    .src_sel  (src_sel),
    .ret_load (ret_load)
  );

  useq_addr_mux #(
    .ADDR_W  (ADDR_W),
    .OPC_W   (OPC_W),
    .MAP_LSB (MAP_LSB)
  ) u_mux (
    .car_q   (car_q),
    .ret_q   (sbr_q),
    .br_addr (br_addr),
    .opcode  (opcode),
    .src_sel (src_sel),
    .car_inc (car_inc),
    .car_nxt (car_nxt)
  );

  // Next-state for the return register
  always_comb begin
    car_en  = 1'b1;
    sbr_nxt = ret_load ? car_inc : sbr_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= CAR_RST;
    end else if (car_en) begin
      car_q <= car_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbr_q <= '0;
    end else if (ret_load) begin
      sbr_q <= sbr_nxt;
    end
  end

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int ADDR_W  = 7,
  parameter int OPC_W   = 4,
  parameter int MAP_LSB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cd_sel,
  input logic [1:0]        br_kind,
  input logic [ADDR_W-1:0] br_addr,
  input logic              ind_bit,
  input logic              acc_sign,
  input logic              acc_zero,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] car_q,
  input logic [ADDR_W-1:0] sbr_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              cond_ok;
  logic [ADDR_W-1:0] map_exp;

  always_comb begin
    case (cd_sel)
      2'd0:    cond_ok = 1'b1;
      2'd1:    cond_ok = ind_bit;
      2'd2:    cond_ok = acc_sign;
      default: cond_ok = acc_zero;
    endcase
    map_exp = ADDR_W'(opcode) << MAP_LSB;
  end

  // R2, R3: taken jump goes to the target
  p_jump_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd0 && cond_ok) |=> car_q == $past(br_addr));

  // R3, R7: untaken jump steps by one with wrap
  p_jump_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd0 && !cond_ok) |=> car_q == $past(car_q) + ONE);

  // R4: taken call saves the return point and branches
  p_call_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd1 && cond_ok) |=> (sbr_q == $past(car_q) + ONE) && (car_q == $past(br_addr)));

  // R5: return restores from the return register
  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd2) |=> car_q == $past(sbr_q));

  // R6: dispatch builds the opcode address
  p_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd3) |=> car_q == $past(map_exp));

  // R8: return register held unless a call is taken
  p_sbr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_kind == 2'd1 && cond_ok) |=> $stable(sbr_q));

endmodule

bind useq_next_addr useq_next_addr_chk #(
  .ADDR_W  (ADDR_W),
  .OPC_W   (OPC_W),
  .MAP_LSB (MAP_LSB)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cd_sel   (cd_sel),
  .br_kind  (br_kind),
  .br_addr  (br_addr),
  .ind_bit  (ind_bit),
  .acc_sign (acc_sign),
  .acc_zero (acc_zero),
  .opcode   (opcode),
  .car_q    (car_q),
  .sbr_q    (sbr_q)
);

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;

  logic       clk;
  logic       rst_n;
  logic [1:0] cd_sel;
  logic [1:0] br_kind;
  logic [6:0] br_addr;
  logic       ind_bit;
  logic       acc_sign;
  logic       acc_zero;
  logic [3:0] opcode;
  logic [6:0] car_q;

  int n_chk;
  int n_fail;
  int m_car;
  int m_sbr;

  useq_next_addr i_useq_next_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cd_sel   (cd_sel),
    .br_kind  (br_kind),
    .br_addr  (br_addr),
    .ind_bit  (ind_bit),
    .acc_sign (acc_sign),
    .acc_zero (acc_zero),
    .opcode   (opcode),
    .car_q    (car_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: car_q=%0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_car = 64;
    m_sbr = 0;
    chk("R1", int'(car_q), 64);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One microinstruction step; expected value from the requirement model
  task automatic step(input string req, input int br, input int cd,
                      input int st, input int opc, input int ad);
    bit cond;
    int inc;
    @(negedge clk);
    br_kind  = 2'(br);
    cd_sel   = 2'(cd);
    ind_bit  = st[0];
    acc_sign = st[1];
    acc_zero = st[2];
    opcode   = 4'(opc);
    br_addr  = 7'(ad);
    case (cd)
      0:       cond = 1'b1;
      1:       cond = st[0];
      2:       cond = st[1];
      default: cond = st[2];
    endcase
    inc = (m_car + 1) % 128;
    case (br)
      0: m_car = cond ? ad : inc;
      1: begin
        if (cond) begin
          m_sbr = inc;
          m_car = ad;
        end else begin
          m_car = inc;
        end
      end
      2: m_car = m_sbr;
      default: m_car = opc * 4;
    endcase
    @(posedge clk);
    #1;
    chk(req, int'(car_q), m_car);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    string lbl;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    cd_sel = '0; br_kind = '0; br_addr = '0;
    ind_bit = 1'b0; acc_sign = 1'b0; acc_zero = 1'b0; opcode = '0;

    // R1: reset value and cleared return register
    do_reset();
    step("R1", 2, 0, 0, 0, 33);
    do_reset();

    // R2: each selector against every flag pattern, jump target varies
    for (int cd = 0; cd < 4; cd++) begin
      for (int st = 0; st < 8; st++) begin
        step("R2", 0, cd, st, 0, 8 + cd * 8 + st);
      end
    end

    // R7: increment wraps from 127
    step("R7", 0, 0, 0, 0, 127);
    step("R7", 0, 1, 0, 0, 50);
    step("R7", 1, 3, 3, 0, 90);

    // Exhaustive sweep of kind x selector x flags x opcode
    for (int br = 0; br < 4; br++) begin
      for (int cd = 0; cd < 4; cd++) begin
        for (int st = 0; st < 8; st++) begin
          for (int opc = 0; opc < 16; opc++) begin
            case (br)
              0: lbl = "R3";
              1: lbl = "R4";
              2: lbl = "R5";
              default: lbl = "R6";
            endcase
            step(lbl, br, cd, st, opc, (br * 53 + cd * 29 + st * 17 + opc * 7) % 128);
          end
        end
      end
    end

    // R8: return register survives other branch kinds
    step("R4", 1, 0, 0, 0, 100);
    step("R8", 1, 1, 0, 0, 20);
    step("R8", 0, 0, 0, 0, 40);
    step("R8", 3, 2, 7, 9, 5);
    step("R8", 1, 2, 0, 0, 70);
    step("R8", 2, 0, 0, 0, 0);
    step("R8", 2, 3, 4, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule